// File: doc/BRIEF.md
# Restoring Sequential Unsigned Divider

This block divides an unsigned dividend of twice the operand width by an unsigned divisor of the operand width. It returns an operand-width quotient and an operand-width remainder. It works one quotient bit per clock using the restoring method.

The dividend is loaded into a remainder register. The divisor is loaded into the upper half of a double-width divisor register, which moves one place to the right after every step. Each step subtracts the divisor register from the remainder. If the difference is negative, the divisor is added back. The quotient shifts left and takes in a 1 when the subtraction succeeded and a 0 when it was restored. The loop runs one more step than the operand width.

A caller pulses a start strobe while the block is idle and then waits for the one-cycle done pulse. Two conditions are settled at once, without running the loop:
- a zero divisor raises a divide-by-zero flag;
- a dividend whose quotient cannot fit in the operand width raises an overflow flag.

The outputs are arranged like a high/low result pair, with the remainder as the high word and the quotient as the low word.

Top module: `seq_restoring_div`

## Requirements
- R1: After reset, busy_o, done_o, div_zero_o and overflow_o are 0, and quotient_o and remainder_o are all zeros.
- R2: A start_i accepted while idle, with a nonzero divisor and no overflow, sets busy_o from the next cycle. done_o is then asserted exactly W+1 clock edges after the accepting edge, and busy_o falls on the same edge.
- R3: For a normal operation, quotient_o equals floor(dividend_i / divisor_i) and remainder_o equals dividend_i mod divisor_i, both W bits wide.
- R4: A zero divisor makes done_o rise on the edge after the accepting edge, with div_zero_o = 1, overflow_o = 0, and quotient_o and remainder_o all zeros.
- R5: With a nonzero divisor, if the upper W bits of the dividend are greater than or equal to the divisor, done_o rises on the next edge with overflow_o = 1, div_zero_o = 0, and quotient_o and remainder_o all zeros.
- R6: A start_i given while busy_o is 1 is ignored. The running operation completes with its own result and its own timing.
- R7: quotient_o, remainder_o, div_zero_o and overflow_o change only on the edge that raises done_o. They hold their values until the next completion.
- R8: done_o lasts exactly one cycle, and busy_o and done_o are never 1 together.
- R9: At the largest dividend that does not overflow (divisor * 2^W - 1), the quotient is all ones and the remainder is divisor - 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| dividend_i | input | 2*W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | W | Quotient (low word of the result pair) |
| remainder_o | output | W | Remainder (high word of the result pair) |
| div_zero_o | output | 1 | Last operation had a zero divisor |
| overflow_o | output | 1 | Last operation's quotient would not fit in W bits |

## Verification
The bench builds the divider with W = 8. This gives a 16-bit dividend and a nine-step loop, so the exact latency can be counted per operation. At this width the overflow boundary is easy to reach: the bench sets the upper dividend byte equal to the divisor and also one step below it. The extreme operands 0x00, 0x01 and 0xFF can be combined with hand-checked expected values. The narrow width also keeps a sweep over several divisor and remainder pairs short enough to include alongside the directed cases for zero divisor, a start given while busy, and output holding.

// File: rtl/divr_pkg.sv
package divr_pkg;
  typedef enum logic {
    DV_IDLE = 1'b0,
    DV_RUN  = 1'b1
  } dv_state_t;
endpackage

// File: rtl/divr_step.sv
// One restoring step: trial subtract, then add the divisor back if the result went negative.
module divr_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] rem_i,
  input  logic [2*W-1:0] dvs_i,
  output logic [2*W-1:0] rem_o,
  output logic           qbit_o
);
  localparam int RW = 2 * W;

  logic [RW:0]   trial;
  logic [RW-1:0] restored;
  logic          negative;

  always_comb begin
    trial    = {1'b0, rem_i} - {1'b0, dvs_i};
    negative = trial[RW];
    restored = trial[RW-1:0] + dvs_i;
    rem_o    = negative ? restored : trial[RW-1:0];
    qbit_o   = ~negative;
  end
endmodule

// File: rtl/divr_iter_cnt.sv
// Step counter: cleared when an operation is accepted, advanced once per step.
module divr_iter_cnt #(
  parameter int LAST = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic adv_i,
  output logic last_o
);
  localparam int CW = $clog2(LAST + 1) + 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == CW'(LAST));

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    adv_i |-> (cnt_q <= CW'(LAST)));  // R2
endmodule

// File: rtl/seq_restoring_div.sv
module seq_restoring_div #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [2*W-1:0] dividend_i,
  input  logic [W-1:0]   divisor_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [W-1:0]   quotient_o,
  output logic [W-1:0]   remainder_o,
  output logic           div_zero_o,
  output logic           overflow_o
);
  import divr_pkg::*;

  localparam int RW    = 2 * W;
  localparam int STEPS = W + 1;

  dv_state_t      st_q;
  logic [RW-1:0]  rem_q;
  logic [RW-1:0]  dvs_q;
  logic [W-1:0]   quo_q;
  logic [RW-1:0]  step_rem;
  logic           step_qbit;
  logic           accept;
  logic           running;
  logic           last_step;
  logic           zero_dvs;
  logic           too_big;
  logic [W-1:0]   quo_next;

  assign accept   = start_i && (st_q == DV_IDLE);
  assign running  = (st_q == DV_RUN);
  assign zero_dvs = (divisor_i == '0);
  assign too_big  = (dividend_i[RW-1:W] >= divisor_i);
  assign quo_next = {quo_q[W-2:0], step_qbit};

  divr_step #(.W(W)) u_step (
    .rem_i  (rem_q),
    .dvs_i  (dvs_q),
    .rem_o  (step_rem),
    .qbit_o (step_qbit)
  );

  divr_iter_cnt #(.LAST(STEPS - 1)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .adv_i  (running),
    .last_o (last_step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= DV_IDLE;
      rem_q       <= '0;
      dvs_q       <= '0;
      quo_q       <= '0;
      done_o      <= 1'b0;
      quotient_o  <= '0;
      remainder_o <= '0;
      div_zero_o  <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        DV_IDLE: begin
          if (start_i) begin
            if (zero_dvs) begin
              done_o      <= 1'b1;
              div_zero_o  <= 1'b1;
              overflow_o  <= 1'b0;
              quotient_o  <= '0;
              remainder_o <= '0;
            end else if (too_big) begin
              done_o      <= 1'b1;
              div_zero_o  <= 1'b0;
              overflow_o  <= 1'b1;
              quotient_o  <= '0;
              remainder_o <= '0;
            end else begin
              rem_q <= dividend_i;
              dvs_q <= {divisor_i, {W{1'b0}}};
              quo_q <= '0;
              st_q  <= DV_RUN;
            end
          end
        end
        default: begin
          rem_q <= step_rem;
          dvs_q <= dvs_q >> 1;
          quo_q <= quo_next;
          if (last_step) begin
            st_q        <= DV_IDLE;
            done_o      <= 1'b1;
            quotient_o  <= quo_next;
            remainder_o <= step_rem[W-1:0];
            div_zero_o  <= 1'b0;
            overflow_o  <= 1'b0;
          end
        end
      endcase
    end
  end

  assign busy_o = running;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);  // R8
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));  // R8
  AST_ZERO_FAST: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && divisor_i == '0) |=> (done_o && div_zero_o && !overflow_o));  // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && divisor_i != '0 && dividend_i[RW-1:W] >= divisor_i)
      |=> (done_o && overflow_o && !div_zero_o));  // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !last_step) |=> busy_o);  // R2
  AST_FIRST_QBIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busy_o && last_step) |-> !quo_q[W-1]);  // R3
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(quotient_o) && $stable(remainder_o));  // R7
endmodule

// File: tb/seq_restoring_div_tb_top.sv
module seq_restoring_div_tb_top;
  localparam int TW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start_i = 1'b0;
  logic [2*TW-1:0] dividend_i = '0;
  logic [TW-1:0]   divisor_i = '0;
  logic            busy_o, done_o, div_zero_o, overflow_o;
  logic [TW-1:0]   quotient_o, remainder_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  seq_restoring_div #(.W(TW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o),
    .quotient_o(quotient_o), .remainder_o(remainder_o),
    .div_zero_o(div_zero_o), .overflow_o(overflow_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Waits for done_o after the accepting edge; returns edges counted past it.
  task automatic wait_done(output int lat);
    lat = 0;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_div(input logic [2*TW-1:0] dvd, input logic [TW-1:0] dvs,
                         input string req);
    int lat;
    int exp_q, exp_r, exp_z, exp_o, exp_lat;
    exp_z = (dvs == 0);
    exp_o = (!exp_z && (dvd >> TW) >= dvs);
    if (exp_z || exp_o) begin
      exp_q = 0; exp_r = 0; exp_lat = 0;
    end else begin
      exp_q = int'(dvd) / int'(dvs);
      exp_r = int'(dvd) % int'(dvs);
      exp_lat = TW + 1;
    end
    @(negedge clk);
    start_i = 1'b1; dividend_i = dvd; divisor_i = dvs;
    @(negedge clk);
    start_i = 1'b0;
    if (exp_lat != 0) chk("R2", "busy after start", int'(busy_o), 1);
    wait_done(lat);
    chk(req, "latency", lat, exp_lat);
    chk("R8", "busy with done", int'(busy_o), 0);
    chk(req, "quotient", int'(quotient_o), exp_q);
    chk(req, "remainder", int'(remainder_o), exp_r);
    chk(exp_z ? "R4" : req, "div_zero", int'(div_zero_o), exp_z);
    chk(exp_o ? "R5" : req, "overflow", int'(overflow_o), exp_o);
    @(negedge clk);
    chk("R8", "done one cycle", int'(done_o), 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "quotient", int'(quotient_o), 0);
    chk("R1", "remainder", int'(remainder_o), 0);
    chk("R1", "div_zero", int'(div_zero_o), 0);
    chk("R1", "overflow", int'(overflow_o), 0);
  endtask

  task automatic t_busy_ignore();
    int lat;
    @(negedge clk);
    start_i = 1'b1; dividend_i = 16'd500; divisor_i = 8'd9;
    @(negedge clk);
    lat = 0;
    start_i = 1'b0;
    repeat (3) begin @(negedge clk); lat++; end
    start_i = 1'b1; dividend_i = 16'd77; divisor_i = 8'd0;
    @(negedge clk);
    lat++;
    start_i = 1'b0;
    chk("R6", "still busy", int'(busy_o), 1);
    while (!done_o && lat < 100) begin @(negedge clk); lat++; end
    chk("R6", "latency", lat, TW + 1);
    chk("R6", "quotient", int'(quotient_o), 55);
    chk("R6", "remainder", int'(remainder_o), 5);
    chk("R6", "div_zero", int'(div_zero_o), 0);
  endtask

  task automatic t_hold();
    logic [TW-1:0] q0, r0;
    run_div(16'd1000, 8'd7, "R3");
    q0 = quotient_o; r0 = remainder_o;
    dividend_i = 16'hFFFF; divisor_i = 8'd1;
    repeat (5) @(negedge clk);
    chk("R7", "quotient held", int'(quotient_o), int'(q0));
    chk("R7", "remainder held", int'(remainder_o), int'(r0));
    chk("R7", "done low", int'(done_o), 0);
    // next op: outputs keep old values while busy
    @(negedge clk);
    start_i = 1'b1; dividend_i = 16'd30; divisor_i = 8'd4;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7", "quotient during run", int'(quotient_o), int'(q0));
    while (!done_o) @(negedge clk);
    chk("R7", "quotient updated", int'(quotient_o), 7);
    chk("R7", "remainder updated", int'(remainder_o), 2);
  endtask

  task automatic t_sweep();
    int dv [4] = '{3, 17, 128, 255};
    foreach (dv[i]) begin
      run_div(16'(dv[i] * 37 + dv[i] - 1), 8'(dv[i]), "R3");
      run_div(16'(dv[i] * 200 + (dv[i] / 2)), 8'(dv[i]), "R3");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    run_div(16'd100, 8'd7, "R3");
    run_div(16'd0, 8'd5, "R3");
    run_div(16'h1234, 8'h13, "R3");
    run_div(16'd200, 8'd200, "R3");
    run_div(16'h00FF, 8'd1, "R3");
    run_div(16'hFEFF, 8'hFF, "R9");
    run_div(16'h0BFF, 8'h0C, "R9");
    run_div(16'd1234, 8'd0, "R4");
    run_div(16'd0, 8'd0, "R4");
    run_div(16'd1000, 8'd3, "R5");
    run_div(16'hFFFF, 8'hFF, "R5");
    run_div(16'h0100, 8'd1, "R5");
    t_busy_ignore();
    t_hold();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule